// File: doc/BRIEF.md
# Receive Interrupt Status Bank

This block holds the sticky receive-side interrupt flags of a flexible-data-rate CAN controller. Single-cycle event strobes and one level input come from the receive path. They set flag bits in a 32-bit status word, which the host reads at any time. The host clears flags by writing ones to a separate clear word. Clearing is write-one-to-clear.

The controller runs in one of two receive modes, mailbox or FIFO. Bits 15 and 16 mean different things in each mode. In mailbox mode the bank also stores two 6-bit buffer indices: one for the last received message and one for the last lost message.

A small mode state machine tracks whether the core is running and which mode applies. It has three states:
- `ST_OFF`: core disabled.
- `ST_MAILBOX`: mailbox mode.
- `ST_FIFO`: FIFO mode.

It has four named transitions:
- `T_ENABLE`: `ST_OFF` to a run state, taken on the first clock edge with the core enabled.
- `T_DISABLE`: any run state to `ST_OFF`, taken when the core-enable input is low or on soft reset.
- `T_TO_FIFO`: `ST_MAILBOX` to `ST_FIFO`.
- `T_TO_MAILBOX`: `ST_FIFO` to `ST_MAILBOX`.

Events are interpreted using the state held before the clock edge. So an event arriving at the `T_ENABLE` edge is dropped. An event arriving at a mode-switch edge is handled under the old mode.

Top module: `rxirq_status_bank`

## Requirements
- R1: Hard reset, a synchronous soft reset, or the core-enable input low at a clock edge clears every flag and both index fields, so the status word reads all zero. Events are ignored while the state is `ST_OFF`.
- R2: From `ST_OFF`, the first edge with core enable high (`T_ENABLE`) enters `ST_MAILBOX` when the mode input is 0 and `ST_FIFO` when it is 1. Events sampled at that edge are dropped. In the run states, the state follows the mode input at every edge.
- R3: A receive-OK strobe sets bit 4 in both modes. In mailbox mode it also loads the received buffer index into bits 23:18. In FIFO mode bits 23:18 keep their value.
- R4: In mailbox mode a buffer-overflow strobe sets bit 16 and loads its index into bits 29:24. With repeated overflows the field holds the most recent index.
- R5: Whenever bit 16 reads 0, bits 29:24 read 0. Clearing bit 16 returns the overflow index to zero.
- R6: A match-not-finished strobe sets bit 17 in both modes.
- R7: In mailbox mode a buffer-full strobe sets bit 15.
- R8: In FIFO mode bit 15 is the FIFO-1 overflow flag. It sets on a FIFO-1 overflow strobe only while FIFO 1 is enabled.
- R9: In FIFO mode, with FIFO 1 enabled, bit 16 is set at every edge where the above-watermark level is high. A clear therefore has no lasting effect while the level holds. With FIFO 1 disabled the level does nothing.
- R10: A transmit-cancel-served strobe sets bit 14.
- R11: A clear write with bit n = 1 clears flag n. If a set and a clear hit the same flag at the same edge, the flag ends up set.
- R12: All status bits other than 29:14 and 4 read 0, and clearing them has no effect. Strobes that belong to the other mode leave the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset |
| core_en | input | 1 | Core enable; low wipes all state |
| fifo_mode | input | 1 | 0 = mailbox mode, 1 = FIFO mode |
| fifo1_en | input | 1 | FIFO 1 enabled |
| rx_ok_ev | input | 1 | Message received strobe |
| rx_buf_idx | input | IDX_W | Buffer index of the received message |
| match_late_ev | input | 1 | ID match did not finish in time; frame dropped |
| tx_cancel_ev | input | 1 | Transmit cancellation served strobe |
| mbx_full_ev | input | 1 | Mailbox receive buffer became full |
| mbx_ovf_ev | input | 1 | Mailbox message lost to overflow |
| mbx_ovf_idx | input | IDX_W | Buffer index of the lost message |
| f1_ovf_ev | input | 1 | Message matching FIFO 1 lost because FIFO 1 is full |
| f1_above_wm | input | 1 | FIFO 1 fill level above full watermark (level) |
| clr_we | input | 1 | Clear-word write strobe |
| clr_data | input | STS_W | Clear word; ones clear the matching flags |
| status | output | STS_W | Status word |

## Verification
The bench builds the bank with its default 6-bit index width and 32-bit status word. This puts the all-ones index 63 within reach, so an index field that ends up misplaced or truncated would collide with neighbouring flag bits in a visible way. A behavioural model holds the mode and flags as plain integers and is compared field by field on every clock. The directed phases cover the enable edge, mode-switch edges, set-versus-clear collisions and the watermark level held through clears. A random phase then mixes every input.

// File: rtl/rxirq_pkg.sv
`timescale 1ns/1ps
package rxirq_pkg;

    typedef enum logic [1:0] {
        ST_OFF     = 2'd0,
        ST_MAILBOX = 2'd1,
        ST_FIFO    = 2'd2
    } rx_mode_e;

    // flag slots inside the flag vector
    localparam int NUM_FLAGS = 5;
    localparam int FL_RXOK   = 0;
    localparam int FL_TXCAN  = 1;
    localparam int FL_FULL   = 2;
    localparam int FL_OVF    = 3;
    localparam int FL_LATE   = 4;

    // bit positions inside the status word
    localparam int POS_RXOK  = 4;
    localparam int POS_TXCAN = 14;
    localparam int POS_FULL  = 15;
    localparam int POS_OVF   = 16;
    localparam int POS_LATE  = 17;
    localparam int POS_RXIDX = 18;

    function automatic int flag_pos(input int slot);
        int pos;
        case (slot)
            FL_RXOK:  pos = POS_RXOK;
            FL_TXCAN: pos = POS_TXCAN;
            FL_FULL:  pos = POS_FULL;
            FL_OVF:   pos = POS_OVF;
            default:  pos = POS_LATE;
        endcase
        return pos;
    endfunction

endpackage

// File: rtl/rxirq_mode_fsm.sv
`timescale 1ns/1ps
module rxirq_mode_fsm
    import rxirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     halt_i,
    input  logic     fifo_mode_i,
    output rx_mode_e state_o,
    output logic     active_o,
    output logic     fifo_o
);

    rx_mode_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF: begin
                if (!halt_i) st_d = fifo_mode_i ? ST_FIFO : ST_MAILBOX;   // T_ENABLE
            end
            ST_MAILBOX: begin
                if (halt_i)           st_d = ST_OFF;                     // T_DISABLE
                else if (fifo_mode_i) st_d = ST_FIFO;                    // T_TO_FIFO
            end
            ST_FIFO: begin
                if (halt_i)            st_d = ST_OFF;                    // T_DISABLE
                else if (!fifo_mode_i) st_d = ST_MAILBOX;                // T_TO_MAILBOX
            end
            default: st_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        active_o = 1'b0;
        fifo_o   = 1'b0;
        unique case (st_q)
            ST_OFF:     active_o = 1'b0;
            ST_MAILBOX: active_o = 1'b1;
            ST_FIFO: begin
                active_o = 1'b1;
                fifo_o   = 1'b1;
            end
            default: active_o = 1'b0;
        endcase
    end

    assign state_o = st_q;

    AST_HALT_TO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> (st_q == ST_OFF));                                    // R2
    AST_RUN_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_i && fifo_mode_i) |=> (st_q == ST_FIFO));                 // R2

endmodule

// File: rtl/rxirq_set_logic.sv
`timescale 1ns/1ps
module rxirq_set_logic
    import rxirq_pkg::*;
(
    input  logic                 active_i,
    input  logic                 fifo_i,
    input  logic                 fifo1_en_i,
    input  logic                 rx_ok_ev_i,
    input  logic                 match_late_ev_i,
    input  logic                 tx_cancel_ev_i,
    input  logic                 mbx_full_ev_i,
    input  logic                 mbx_ovf_ev_i,
    input  logic                 f1_ovf_ev_i,
    input  logic                 f1_above_wm_i,
    output logic [NUM_FLAGS-1:0] set_o,
    output logic                 cap_rx_o,
    output logic                 cap_ovf_o
);

    always_comb begin
        set_o = '0;
        if (active_i) begin
            set_o[FL_RXOK]  = rx_ok_ev_i;
            set_o[FL_LATE]  = match_late_ev_i;
            set_o[FL_TXCAN] = tx_cancel_ev_i;
            if (fifo_i) begin
                set_o[FL_OVF]  = fifo1_en_i & f1_above_wm_i;
                set_o[FL_FULL] = fifo1_en_i & f1_ovf_ev_i;
            end else begin
                set_o[FL_OVF]  = mbx_ovf_ev_i;
                set_o[FL_FULL] = mbx_full_ev_i;
            end
        end
    end

    assign cap_rx_o  = active_i & ~fifo_i & rx_ok_ev_i;
    assign cap_ovf_o = active_i & ~fifo_i & mbx_ovf_ev_i;

endmodule

// File: rtl/rxirq_flag_bit.sv
`timescale 1ns/1ps
module rxirq_flag_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic wipe_i,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o,
    output logic nxt_o
);

    logic q;

    assign nxt_o = ~wipe_i & (set_i | (q & ~clr_i));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= nxt_o;
    end

    assign q_o = q;

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !wipe_i) |=> q_o);                                     // R11
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);                                     // R11

endmodule

// File: rtl/rxirq_index_slot.sv
`timescale 1ns/1ps
module rxirq_index_slot #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wipe_i,
    input  logic         cap_i,
    input  logic [W-1:0] val_i,
    input  logic         keep_i,
    output logic [W-1:0] idx_o
);

    logic [W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       idx_q <= '0;
        else if (wipe_i)  idx_q <= '0;
        else if (cap_i)   idx_q <= val_i;
        else if (!keep_i) idx_q <= '0;
    end

    assign idx_o = idx_q;

    AST_CAPTURE_LATEST: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i && !wipe_i) |=> (idx_o == $past(val_i)));                 // R4

endmodule

// File: rtl/rxirq_status_bank.sv
`timescale 1ns/1ps
module rxirq_status_bank
    import rxirq_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int STS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             core_en,
    input  logic             fifo_mode,
    input  logic             fifo1_en,
    input  logic             rx_ok_ev,
    input  logic [IDX_W-1:0] rx_buf_idx,
    input  logic             match_late_ev,
    input  logic             tx_cancel_ev,
    input  logic             mbx_full_ev,
    input  logic             mbx_ovf_ev,
    input  logic [IDX_W-1:0] mbx_ovf_idx,
    input  logic             f1_ovf_ev,
    input  logic             f1_above_wm,
    input  logic             clr_we,
    input  logic [STS_W-1:0] clr_data,
    output logic [STS_W-1:0] status
);

    localparam int OVF_IDX_LSB = POS_RXIDX + IDX_W;

    logic                 wipe;
    rx_mode_e             state;
    logic                 active, in_fifo;
    logic [NUM_FLAGS-1:0] set_vec, clr_vec, flag_q, flag_nxt;
    logic                 cap_rx, cap_ovf;
    logic [IDX_W-1:0]     rx_idx_q, ovf_idx_q;

    assign wipe = soft_rst | ~core_en;

    rxirq_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .halt_i      (wipe),
        .fifo_mode_i (fifo_mode),
        .state_o     (state),
        .active_o    (active),
        .fifo_o      (in_fifo)
    );

    rxirq_set_logic u_set (
        .active_i        (active),
        .fifo_i          (in_fifo),
        .fifo1_en_i      (fifo1_en),
        .rx_ok_ev_i      (rx_ok_ev),
        .match_late_ev_i (match_late_ev),
        .tx_cancel_ev_i  (tx_cancel_ev),
        .mbx_full_ev_i   (mbx_full_ev),
        .mbx_ovf_ev_i    (mbx_ovf_ev),
        .f1_ovf_ev_i     (f1_ovf_ev),
        .f1_above_wm_i   (f1_above_wm),
        .set_o           (set_vec),
        .cap_rx_o        (cap_rx),
        .cap_ovf_o       (cap_ovf)
    );

    // route clear-word bits to flag slots by status position
    always_comb begin
        clr_vec = '0;
        for (int p = 0; p < STS_W; p++) begin
            for (int f = 0; f < NUM_FLAGS; f++) begin
                if (flag_pos(f) == p) clr_vec[f] = clr_vec[f] | (clr_we & clr_data[p]);
            end
        end
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        rxirq_flag_bit u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .wipe_i (wipe),
            .set_i  (set_vec[g]),
            .clr_i  (clr_vec[g]),
            .q_o    (flag_q[g]),
            .nxt_o  (flag_nxt[g])
        );
    end

    rxirq_index_slot #(.W(IDX_W)) u_rx_idx (
        .clk    (clk),
        .rst_n  (rst_n),
        .wipe_i (wipe),
        .cap_i  (cap_rx),
        .val_i  (rx_buf_idx),
        .keep_i (1'b1),
        .idx_o  (rx_idx_q)
    );

    rxirq_index_slot #(.W(IDX_W)) u_ovf_idx (
        .clk    (clk),
        .rst_n  (rst_n),
        .wipe_i (wipe),
        .cap_i  (cap_ovf),
        .val_i  (mbx_ovf_idx),
        .keep_i (flag_nxt[FL_OVF]),
        .idx_o  (ovf_idx_q)
    );

    always_comb begin
        status = '0;
        for (int f = 0; f < NUM_FLAGS; f++) status[flag_pos(f)] = flag_q[f];
        status[POS_RXIDX +: IDX_W]   = rx_idx_q;
        status[OVF_IDX_LSB +: IDX_W] = ovf_idx_q;
    end

    AST_WIPE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (status == '0));                                        // R1
    AST_OVF_IDX_TIED: assert property (@(posedge clk) disable iff (!rst_n)
        !status[POS_OVF] |-> (status[OVF_IDX_LSB +: IDX_W] == '0));      // R5
    AST_WM_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIFO && !wipe && fifo1_en && f1_above_wm) |=> status[POS_OVF]); // R9
    AST_FIFO1_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIFO && !fifo1_en && !status[POS_FULL]) |=> !status[POS_FULL]); // R8
    AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |=> (status == '0));                           // R1

endmodule

// File: tb/test_rxirq_status_bank.sv
`timescale 1ns/1ps
module test_rxirq_status_bank;

    localparam int IDX_W = 6;
    localparam int STS_W = 32;
    localparam logic [31:0] FLAGMASK = 32'h0003_C010;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             soft_rst = 1'b0, core_en = 1'b0, fifo_mode = 1'b0, fifo1_en = 1'b0;
    logic             rx_ok_ev = 1'b0, match_late_ev = 1'b0, tx_cancel_ev = 1'b0;
    logic             mbx_full_ev = 1'b0, mbx_ovf_ev = 1'b0, f1_ovf_ev = 1'b0, f1_above_wm = 1'b0;
    logic [IDX_W-1:0] rx_buf_idx = '0, mbx_ovf_idx = '0;
    logic             clr_we = 1'b0;
    logic [STS_W-1:0] clr_data = '0;
    logic [STS_W-1:0] status;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    // behavioural model state
    int          m_st = 0;          // 0 off, 1 mailbox, 2 fifo
    logic [31:0] m_flags = '0;
    int          m_rx = 0;
    int          m_ov = 0;

    always #2.5 clk = ~clk;

    rxirq_status_bank #(.IDX_W(IDX_W), .STS_W(STS_W)) i_rxirq_status_bank (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .core_en(core_en),
        .fifo_mode(fifo_mode), .fifo1_en(fifo1_en), .rx_ok_ev(rx_ok_ev),
        .rx_buf_idx(rx_buf_idx), .match_late_ev(match_late_ev),
        .tx_cancel_ev(tx_cancel_ev), .mbx_full_ev(mbx_full_ev),
        .mbx_ovf_ev(mbx_ovf_ev), .mbx_ovf_idx(mbx_ovf_idx), .f1_ovf_ev(f1_ovf_ev),
        .f1_above_wm(f1_above_wm), .clr_we(clr_we), .clr_data(clr_data),
        .status(status)
    );

    always @(posedge clk) begin
        logic [31:0] sets;
        logic [31:0] clrs;
        bit halt;
        halt = !rst_n || soft_rst || !core_en;
        if (halt) begin
            m_flags = '0; m_rx = 0; m_ov = 0;
        end else begin
            sets = '0;
            if (m_st != 0) begin
                if (rx_ok_ev)      sets[4]  = 1'b1;
                if (match_late_ev) sets[17] = 1'b1;
                if (tx_cancel_ev)  sets[14] = 1'b1;
                if (m_st == 1) begin
                    if (mbx_ovf_ev)  sets[16] = 1'b1;
                    if (mbx_full_ev) sets[15] = 1'b1;
                    if (rx_ok_ev)    m_rx = int'(rx_buf_idx);
                end else begin
                    if (fifo1_en && f1_above_wm) sets[16] = 1'b1;
                    if (fifo1_en && f1_ovf_ev)   sets[15] = 1'b1;
                end
            end
            clrs = clr_we ? (clr_data & FLAGMASK) : '0;
            m_flags = sets | (m_flags & ~clrs);
            if (m_st == 1 && mbx_ovf_ev) m_ov = int'(mbx_ovf_idx);
            else if (!m_flags[16])       m_ov = 0;
        end
        m_st = halt ? 0 : (fifo_mode ? 2 : 1);
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R3",  "rxok bit",   int'(status[4]),      int'(m_flags[4]));
            chk("R3",  "rx index",   int'(status[23:18]),  m_rx);
            chk("R4",  "ovf index",  int'(status[29:24]),  m_ov);
            chk("R6",  "late bit",   int'(status[17]),     int'(m_flags[17]));
            chk("R9",  "bit16",      int'(status[16]),     int'(m_flags[16]));
            chk("R7",  "bit15",      int'(status[15]),     int'(m_flags[15]));
            chk("R10", "txcan bit",  int'(status[14]),     int'(m_flags[14]));
            chk("R12", "unused",     int'(status[13:0] & ~14'h0010) | int'(status[31:30]), 0);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle();
        rx_ok_ev = 0; match_late_ev = 0; tx_cancel_ev = 0; mbx_full_ev = 0;
        mbx_ovf_ev = 0; f1_ovf_ev = 0; clr_we = 0; clr_data = '0; soft_rst = 0;
    endtask

    task automatic clear(input logic [31:0] w);
        clr_we = 1; clr_data = w; tick(); idle();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1; cmp_on = 1;
        chk("R1", "reset status", int'(status), 0);
        // events while disabled are ignored (R1)
        rx_ok_ev = 1; tx_cancel_ev = 1; tick(); idle();
        chk("R1", "disabled ignore", int'(status), 0);
        // enable edge drops the event (R2)
        core_en = 1; rx_ok_ev = 1; rx_buf_idx = 6'd9; tick(); idle();
        chk("R2", "enable edge drop", int'(status), 0);
        // mailbox receive (R3)
        rx_ok_ev = 1; rx_buf_idx = 6'd5; tick(); idle();
        chk("R3", "rx ok word", int'(status), (1 << 4) | (5 << 18));
        // repeated overflow keeps latest (R4)
        mbx_ovf_ev = 1; mbx_ovf_idx = 6'd10; tick();
        mbx_ovf_idx = 6'd63; tick(); idle();
        chk("R4", "latest ovf idx", int'(status[29:24]), 63);
        // clearing bit16 zeroes the index (R5)
        clear(32'h0001_0000);
        chk("R5", "ovf idx cleared", int'(status[29:24]), 0);
        chk("R5", "ovf bit cleared", int'(status[16]), 0);
        // late match, cancel, buffer full (R6, R7, R10)
        match_late_ev = 1; tx_cancel_ev = 1; mbx_full_ev = 1; tick(); idle();
        chk("R6", "late", int'(status[17]), 1);
        chk("R7", "full", int'(status[15]), 1);
        chk("R10", "txcan", int'(status[14]), 1);
        // set wins over clear at the same edge (R11)
        tx_cancel_ev = 1; clr_we = 1; clr_data = 32'h0000_4000; tick(); idle();
        chk("R11", "set beats clear", int'(status[14]), 1);
        clear(32'h0000_4000);
        chk("R11", "w1c", int'(status[14]), 0);
        // all-ones clear; reserved bits stay zero (R12)
        clear(32'hFFFF_FFFF);
        chk("R12", "after full clear", int'(status), 5 << 18);
        // switch to FIFO mode
        fifo_mode = 1; tick();
        f1_above_wm = 1; f1_ovf_ev = 1; tick(); idle();
        chk("R8", "fifo1 disabled ovf", int'(status[15]), 0);
        chk("R9", "fifo1 disabled wm", int'(status[16]), 0);
        fifo1_en = 1; tick();
        clear(32'h0001_0000);
        chk("R9", "wm reasserts", int'(status[16]), 1);
        f1_above_wm = 0; tick();
        clear(32'h0001_0000);
        chk("R9", "wm released", int'(status[16]), 0);
        f1_ovf_ev = 1; tick(); idle();
        chk("R8", "fifo1 ovf", int'(status[15]), 1);
        // mailbox strobes ignored in FIFO mode, rx idx held (R12, R3)
        mbx_ovf_ev = 1; mbx_ovf_idx = 6'd33; rx_ok_ev = 1; rx_buf_idx = 6'd44; tick(); idle();
        chk("R12", "mbx ovf ignored", int'(status[16]), 0);
        chk("R3", "fifo rx idx held", int'(status[23:18]), 5);
        // soft reset and disable wipe (R1)
        soft_rst = 1; tick(); idle();
        chk("R1", "soft reset", int'(status), 0);
        tick(); tx_cancel_ev = 1; tick(); idle();
        core_en = 0; tick();
        chk("R1", "disable wipe", int'(status), 0);
        core_en = 1; tick();
        // random mix
        for (int i = 0; i < 3000; i++) begin
            rx_ok_ev = ($urandom % 4) == 0;   rx_buf_idx = 6'($urandom);
            match_late_ev = ($urandom % 8) == 0; tx_cancel_ev = ($urandom % 8) == 0;
            mbx_full_ev = ($urandom % 6) == 0; mbx_ovf_ev = ($urandom % 5) == 0;
            mbx_ovf_idx = 6'($urandom); f1_ovf_ev = ($urandom % 6) == 0;
            f1_above_wm = ($urandom % 3) == 0; fifo1_en = ($urandom % 4) != 0;
            clr_we = ($urandom % 3) == 0; clr_data = $urandom;
            if (($urandom % 40) == 0) fifo_mode = ~fifo_mode;
            soft_rst = ($urandom % 200) == 0;
            core_en = ($urandom % 150) != 0;
            tick();
        end
        idle(); core_en = 1; tick(); tick();
        finish_run();
    end

endmodule